// File: doc/BRIEF.md
# Interrupt Virtualization Exit Controller

This block decides, cycle by cycle, whether interrupt-related activity seen while a guest runs must hand control back to the hypervisor. The hypervisor sets three controls. The first makes every external interrupt request exit. The second makes the block exit as soon as the guest can accept interrupts. The third redirects the guest's task-priority accesses to a local shadow copy, and a programmable threshold is compared against that copy.

When an exit condition holds, the block emits a one-cycle exit request with a reason code. It then stays parked and drops further events until the host pulses a resume input. Priority writes that fall below the threshold are remembered. The exit for such a write is raised when a later instruction-retire strobe arrives, so the exit comes after the instruction that lowered the priority. When shadowing is off, guest priority accesses pass straight through to the real register interface.

Top module: `intvirt_exit_ctrl`

## Requirements
- R1: After reset, exit_req and exit_reason are 0, the block is not parked, and with shadowing on, prio_rdata reads 0.
- R2: With cfg_ext_exit set and the block not parked, an ext_irq sampled high at a clock edge raises exit_req with exit_reason 1 after that edge, whatever guest_irq_en is.
- R3: With cfg_win_exit set and the block not parked, guest_irq_en high with guest_irq_hold low raises exit_req with exit_reason 2 after that edge. A window exit is not raised while guest_irq_hold is high or guest_irq_en is low.
- R4: With cfg_prio_shadow set, a prio_wr loads prio_wdata into the shadow, prio_rdata returns the shadow from the next cycle, and hw_prio_we stays 0. With shadowing off, hw_prio_we follows prio_wr, hw_prio_wdata equals prio_wdata, and prio_rdata equals hw_prio_rdata.
- R5: A shadowed write while not parked whose value is unsigned strictly less than cfg_prio_thresh arms a pending flag. The first insn_retire in a later cycle, while not parked, raises exit_req with exit_reason 3 and clears the flag. A write of a value at or above the threshold, or any write with shadowing off, arms nothing.
- R6: When several conditions hold at one edge, the reason is the lowest code: 1 over 2 over 3. A pending priority exit that loses stays pending.
- R7: exit_req is high for exactly one cycle. After it, ext and window events are dropped until a cycle with host_resume high has passed.
- R8: exit_reason is 0 whenever exit_req is 0, and is nonzero whenever exit_req is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ext_exit | input | 1 | Exit on every external interrupt |
| cfg_win_exit | input | 1 | Exit when guest can take interrupts |
| cfg_prio_shadow | input | 1 | Redirect guest priority accesses to shadow |
| cfg_prio_thresh | input | PRIO_W | Threshold for the shadow priority |
| ext_irq | input | 1 | External interrupt request |
| guest_irq_en | input | 1 | Guest interrupt-enable flag |
| guest_irq_hold | input | 1 | One-instruction interrupt blocking active |
| prio_wr | input | 1 | Guest priority write strobe |
| prio_wdata | input | PRIO_W | Guest priority write value |
| prio_rdata | output | PRIO_W | Value returned to guest priority reads |
| hw_prio_we | output | 1 | Write strobe to the real priority register |
| hw_prio_wdata | output | PRIO_W | Write value to the real priority register |
| hw_prio_rdata | input | PRIO_W | Current value of the real priority register |
| insn_retire | input | 1 | Guest instruction retired |
| host_resume | input | 1 | Host re-enables exit detection |
| exit_req | output | 1 | One-cycle exit request |
| exit_reason | output | 2 | Exit reason code (1 ext, 2 window, 3 priority) |

## Verification
A stuck parked flag would show up as exits that never come back after a resume. A lost park would show up as a second exit_req in the cycle right after the first. Either one appears within one or two cycles of the next qualifying event. A wrong pending-priority flag shows at the next retire strobe: an exit 3 appears that should not, or is missing. A wrong shadow register shows on prio_rdata in the cycle after the write. Wrong priority ordering shows as the reason code on the same exit pulse.

// File: rtl/intvirt_exit_ctrl.sv
module intvirt_exit_ctrl #(
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ext_exit,
  input  logic              cfg_win_exit,
  input  logic              cfg_prio_shadow,
  input  logic [PRIO_W-1:0] cfg_prio_thresh,
  input  logic              ext_irq,
  input  logic              guest_irq_en,
  input  logic              guest_irq_hold,
  input  logic              prio_wr,
  input  logic [PRIO_W-1:0] prio_wdata,
  output logic [PRIO_W-1:0] prio_rdata,
  output logic              hw_prio_we,
  output logic [PRIO_W-1:0] hw_prio_wdata,
  input  logic [PRIO_W-1:0] hw_prio_rdata,
  input  logic              insn_retire,
  input  logic              host_resume,
  output logic              exit_req,
  output logic [1:0]        exit_reason
);

  localparam logic [1:0] RSN_NONE = 2'd0;
  localparam logic [1:0] RSN_EXT  = 2'd1;
  localparam logic [1:0] RSN_WIN  = 2'd2;
  localparam logic [1:0] RSN_PRIO = 2'd3;

  logic              parked;
  logic              below_pend;
  logic [PRIO_W-1:0] shadow;

  wire hit_ext   = !parked && cfg_ext_exit && ext_irq;
  wire hit_win   = !parked && cfg_win_exit && guest_irq_en && !guest_irq_hold;
  wire hit_prio  = !parked && below_pend && insn_retire;
  wire any_hit   = hit_ext || hit_win || hit_prio;
  wire prio_wins = hit_prio && !hit_ext && !hit_win;
  wire shadow_wr = prio_wr && cfg_prio_shadow;

  assign prio_rdata    = cfg_prio_shadow ? shadow : hw_prio_rdata;
  assign hw_prio_we    = prio_wr && !cfg_prio_shadow;
  assign hw_prio_wdata = prio_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow <= '0;
    else if (shadow_wr) shadow <= prio_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) below_pend <= 1'b0;
    else if (shadow_wr && !parked) below_pend <= (prio_wdata < cfg_prio_thresh);
    else if (prio_wins) below_pend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) parked <= 1'b0;
    else if (any_hit) parked <= 1'b1;
    else if (host_resume) parked <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exit_req    <= 1'b0;
      exit_reason <= RSN_NONE;
    end else begin
      exit_req    <= any_hit;
      exit_reason <= hit_ext ? RSN_EXT : hit_win ? RSN_WIN : hit_prio ? RSN_PRIO : RSN_NONE;
    end
  end

  AST_EXT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!parked && cfg_ext_exit && ext_irq) |=> (exit_req && exit_reason == RSN_EXT)); // R2
  AST_WIN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!parked && !(cfg_ext_exit && ext_irq) && cfg_win_exit && guest_irq_en && !guest_irq_hold)
      |=> (exit_req && exit_reason == RSN_WIN)); // R3
  AST_SHADOW_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_wr && cfg_prio_shadow) |=> (!cfg_prio_shadow || prio_rdata == $past(prio_wdata))); // R4
  AST_PRIO_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    prio_wins |=> (exit_req && exit_reason == RSN_PRIO)); // R5
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req |=> !exit_req); // R7
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (parked && !host_resume) |=> !exit_req); // R7
  AST_REASON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_req == (exit_reason != RSN_NONE))); // R8

endmodule

// File: tb/intvirt_exit_ctrl_bench.sv
module intvirt_exit_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_ext_exit = 0, cfg_win_exit = 0, cfg_prio_shadow = 0;
  logic [PW-1:0] cfg_prio_thresh = '0;
  logic ext_irq = 0, guest_irq_en = 0, guest_irq_hold = 0;
  logic prio_wr = 0;
  logic [PW-1:0] prio_wdata = '0;
  logic [PW-1:0] prio_rdata;
  logic hw_prio_we;
  logic [PW-1:0] hw_prio_wdata;
  logic [PW-1:0] hw_prio_rdata = 4'hA;
  logic insn_retire = 0, host_resume = 0;
  logic exit_req;
  logic [1:0] exit_reason;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intvirt_exit_ctrl #(.PRIO_W(PW)) u_intvirt_exit_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_ext_exit(cfg_ext_exit), .cfg_win_exit(cfg_win_exit),
    .cfg_prio_shadow(cfg_prio_shadow), .cfg_prio_thresh(cfg_prio_thresh),
    .ext_irq(ext_irq), .guest_irq_en(guest_irq_en), .guest_irq_hold(guest_irq_hold),
    .prio_wr(prio_wr), .prio_wdata(prio_wdata), .prio_rdata(prio_rdata),
    .hw_prio_we(hw_prio_we), .hw_prio_wdata(hw_prio_wdata), .hw_prio_rdata(hw_prio_rdata),
    .insn_retire(insn_retire), .host_resume(host_resume),
    .exit_req(exit_req), .exit_reason(exit_reason));

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic resume();
    ext_irq = 0; guest_irq_en = 0; guest_irq_hold = 0; insn_retire = 0; prio_wr = 0;
    host_resume = 1;
    tick();
    host_resume = 0;
  endtask

  task automatic exit_is(string req, int rsn);
    check(req, exit_req, rsn != 0);
    check(req, exit_reason, rsn);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    cfg_prio_shadow = 1;
    #1;
    check("R1 exit_req", exit_req, 0);
    check("R1 exit_reason", exit_reason, 0);
    check("R1 shadow", prio_rdata, 0);
    rst_n = 1;
    cfg_prio_shadow = 0;
    tick();

    // R2 R3 R7 R8 sweep over every combination of the event controls
    for (int v = 0; v < 32; v++) begin
      int e, w, rsn;
      cfg_ext_exit = v[0]; cfg_win_exit = v[1]; ext_irq = v[2];
      guest_irq_en = v[3]; guest_irq_hold = v[4];
      e = v[0] & v[2];
      w = v[1] & v[3] & ~v[4];
      rsn = e ? 1 : (w ? 2 : 0);
      tick();
      exit_is(e ? "R2 ext exit" : "R3 window exit", rsn);
      tick();
      exit_is("R7 parked drops events", (rsn != 0) ? 0 : rsn);
      resume();
    end
    cfg_ext_exit = 0; cfg_win_exit = 0;

    // R4 R5 threshold sweep with shadowing on
    cfg_prio_shadow = 1;
    for (int t = 0; t < 16; t++) begin
      for (int wv = 0; wv < 16; wv++) begin
        cfg_prio_thresh = t[PW-1:0];
        prio_wr = 1; prio_wdata = wv[PW-1:0];
        #1;
        check("R4 no hw write when shadowed", hw_prio_we, 0);
        tick();
        prio_wr = 0;
        check("R4 shadow readback", prio_rdata, wv);
        exit_is("R5 no exit before retire", 0);
        insn_retire = 1;
        tick();
        insn_retire = 0;
        exit_is("R5 below threshold exit", (wv < t) ? 3 : 0);
        resume();
      end
    end

    // R4 R5 pass-through with shadowing off
    cfg_prio_shadow = 0; cfg_prio_thresh = 4'd8;
    prio_wr = 1; prio_wdata = 4'd3;
    #1;
    check("R4 hw write strobe", hw_prio_we, 1);
    check("R4 hw write data", hw_prio_wdata, 3);
    check("R4 hw readback", prio_rdata, 4'hA);
    tick();
    prio_wr = 0;
    insn_retire = 1;
    tick();
    insn_retire = 0;
    exit_is("R5 unshadowed write arms nothing", 0);

    // R6 priority ordering with a pending priority exit
    cfg_prio_shadow = 1; cfg_prio_thresh = 4'd5;
    prio_wr = 1; prio_wdata = 4'd0;
    tick();
    prio_wr = 0;
    cfg_ext_exit = 1; cfg_win_exit = 1;
    ext_irq = 1; guest_irq_en = 1; insn_retire = 1;
    tick();
    exit_is("R6 ext beats all", 1);
    resume();
    guest_irq_en = 1; insn_retire = 1;
    tick();
    exit_is("R6 window beats priority", 2);
    resume();
    insn_retire = 1;
    tick();
    exit_is("R6 pending priority kept", 3);
    resume();
    insn_retire = 1;
    tick();
    exit_is("R5 pending cleared after exit", 0);
    insn_retire = 0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule